// File: doc/BRIEF.md
# Audio Channel Sample FIFO with Holding-Register Bypass

This block is the data path of one audio controller channel. A host-side write port and a host-side read port share one data word. Words written by the host queue up in a transmit FIFO. A serial framer drains that FIFO one sample at a time. Samples from the framer arrive tagged with their slot number. A sample is kept only when reception and that slot are both enabled, and kept samples queue in a receive FIFO for the host to read. Both FIFOs have a parameterised depth and export full and empty flags.

The FIFOs can be switched off. Each direction then shrinks to a single holding register, which is the FIFO's bottom entry, and a new word overwrites the old one. Every receive entry carries one extra tag bit that records a lost word. In FIFO mode, a sample that arrives while the receive FIFO is full is dropped, and the tag is set on the newest stored entry. In holding mode, a word that overwrites an unread word carries the tag. The tag never appears in the read data. It is reported on a separate status output next to the word last read.

In normal mode a word carries one 20-bit sample. In compact mode one 32-bit word holds two 16-bit samples. A sample on the serial side is 20 bits wide with its 16-bit value aligned to the most significant end.

Top module: `achan_fifo_top`

## Requirements
- R1: After reset, host_rdata, rx_overrun and tx_sample are 0, tx_empty and rx_empty are 1, and tx_full and rx_full are 0.
- R2: In normal FIFO mode, each host write queues host_wdata[19:0]. tx_sample shows the oldest queued word zero-extended to bits 19:0, and each tx_take removes it, in write order.
- R3: A serial sample is accepted only when rx_ctrl[0] is 1, rx_slot is between 1 and 12, and rx_ctrl[rx_slot] is 1. Any other sample leaves rx_empty unchanged.
- R4: An accepted normal-mode sample becomes readable two clock edges after it is presented. A host_rd pop updates host_rdata at the next edge, in arrival order, with bits 31:20 zero.
- R5: With FIFOs enabled, each FIFO raises its full flag once it holds DEPTH words and raises its empty flag once it holds none.
- R6: In FIFO mode, a sample accepted while the receive FIFO is full is discarded, and the tag of the newest stored entry is set. rx_overrun shows the tag of the word last read, and the tag never appears in host_rdata.
- R7: A host_rd while the receive side is empty leaves host_rdata and rx_overrun unchanged and removes nothing.
- R8: A host write while the transmit FIFO is full is discarded, and the queued words are unaffected.
- R9: With cfg_fifo_off set, each direction holds one word. A host write overwrites the transmit holding word, tx_full is 1 while that word is unconsumed, and one tx_take empties it.
- R10: With cfg_fifo_off set, a received word that overwrites an unread holding word is stored with its tag set. A word stored into an empty holding register has its tag clear.
- R11: In compact mode, two accepted samples form one receive word. The first sample's bits 19:4 go to bits 15:0 and the second sample's bits 19:4 go to bits 31:16. Nothing becomes readable after the first sample alone.
- R12: In compact mode, tx_sample first shows {word[15:0],4'h0} and then {word[31:16],4'h0}. The word leaves the transmit FIFO only on the second tx_take.
- R13: Changing cfg_fifo_off empties both directions at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_off | input | 1 | 1 selects single holding registers instead of FIFOs |
| cfg_compact | input | 1 | 1 selects two 16-bit samples per 32-bit word |
| rx_ctrl | input | 13 | Bit 0 enables reception, bits 1..12 enable slots 1..12 |
| host_wr | input | 1 | Host write strobe to the data word |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe, pops one receive word |
| host_rdata | output | 32 | Last word read from the receive side |
| rx_overrun | output | 1 | Loss tag of the last word read |
| rx_valid | input | 1 | Serial side presents a received sample |
| rx_slot | input | 4 | Slot number of the presented sample |
| rx_sample | input | 20 | Received sample |
| tx_take | input | 1 | Serial side consumes the shown transmit sample |
| tx_sample | output | 20 | Current transmit sample |
| tx_full | output | 1 | Transmit side cannot accept another word |
| tx_empty | output | 1 | Transmit side holds no word |
| rx_full | output | 1 | Receive side is full |
| rx_empty | output | 1 | Receive side holds no word |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, a handful of samples fills either FIFO, so the full flag, a write dropped on the transmit side, and a sample dropped with its tag moved onto the newest entry can all be reached in a few cycles. The small depth also makes the pointers wrap inside the overrun scenario, so a pop after the wrap checks that order and tag placement still line up. Holding-register mode, the flush when the mode changes, and compact packing in both directions are then driven against that same small instance.

// File: rtl/achan_pkg.sv
package achan_pkg;
    localparam int SLOT_CNT = 12;
    localparam int SAMPLE_W = 20;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int PAD_W    = SAMPLE_W - HALF_W;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;
endpackage

// File: rtl/achan_fifo.sv
module achan_fifo #(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter bit TAG_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wptr;
        logic [AW-1:0]            rptr;
        logic [CW-1:0]            cnt;
        logic                     bypass;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic          is_full, is_empty, do_push, do_pop;
    logic [AW-1:0] newest;

    always_comb begin
        s_d      = s_q;
        is_full  = (s_q.cnt == CW'(DEPTH));
        is_empty = (s_q.cnt == '0);
        do_pop   = 1'b0;
        do_push  = 1'b0;
        newest   = (s_q.wptr == '0) ? AW'(DEPTH - 1) : s_q.wptr - 1'b1;
        s_d.bypass = bypass_i;

        if (bypass_i != s_q.bypass) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
        end else if (s_q.bypass) begin
            if (push_i) begin
                s_d.mem[0] = push_data_i;
                if (TAG_EN && !is_empty && !pop_i) begin
                    s_d.mem[0][DW-1] = 1'b1;
                end
                s_d.cnt = CW'(1);
            end else if (pop_i) begin
                s_d.cnt = '0;
            end
        end else begin
            do_pop  = pop_i && !is_empty;
            do_push = push_i && (!is_full || do_pop);
            if (do_push) begin
                s_d.mem[s_q.wptr] = push_data_i;
                s_d.wptr          = ptr_inc(s_q.wptr);
            end else if (push_i && TAG_EN) begin
                s_d.mem[newest][DW-1] = 1'b1;
            end
            if (do_pop) begin
                s_d.rptr = ptr_inc(s_q.rptr);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o  = s_q.mem[s_q.rptr];
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = s_q.bypass ? (s_q.cnt != '0) : (s_q.cnt == CW'(DEPTH));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R5

    AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bypass |-> (s_q.cnt <= CW'(1))); // R9

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !s_q.bypass && !bypass_i && s_q.cnt == CW'(DEPTH))
        |=> (s_q.cnt == CW'(DEPTH)) && $stable(s_q.wptr)); // R8

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i != s_q.bypass) |=> empty_o); // R13
endmodule

// File: rtl/achan_rx_pack.sv
module achan_rx_pack
    import achan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                compact_i,
    input  logic [SLOT_CNT:0]   ctrl_i,
    input  logic                valid_i,
    input  logic [3:0]          slot_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                push_o,
    output logic [WORD_W-1:0]   word_o
);
    typedef struct packed {
        lane_e               lane;
        logic [HALF_W-1:0]   low;
        logic                push;
        logic [WORD_W-1:0]   word;
        logic                compact;
    } pack_t;

    pack_t p_q, p_d;
    logic  slot_on, accept;

    always_comb begin
        slot_on = 1'b0;
        for (int s = 1; s <= SLOT_CNT; s++) begin
            if (slot_i == 4'(s)) begin
                slot_on = ctrl_i[s];
            end
        end
        accept = valid_i && ctrl_i[0] && slot_on;

        p_d         = p_q;
        p_d.push    = 1'b0;
        p_d.compact = compact_i;

        if (compact_i != p_q.compact) begin
            p_d.lane = LANE_LO;
        end else if (accept) begin
            if (!compact_i) begin
                p_d.push = 1'b1;
                p_d.word = {{(WORD_W - SAMPLE_W){1'b0}}, sample_i};
            end else if (p_q.lane == LANE_LO) begin
                p_d.low  = sample_i[SAMPLE_W-1:PAD_W];
                p_d.lane = LANE_HI;
            end else begin
                p_d.push = 1'b1;
                p_d.word = {sample_i[SAMPLE_W-1:PAD_W], p_q.low};
                p_d.lane = LANE_LO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign push_o = p_q.push;
    assign word_o = p_q.word;

    AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ctrl_i[0]) |=> !push_o); // R3
endmodule

// File: rtl/achan_tx_unpack.sv
module achan_tx_unpack
    import achan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                compact_i,
    input  logic [WORD_W-1:0]   word_i,
    input  logic                empty_i,
    input  logic                take_i,
    output logic                pop_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    typedef struct packed {
        lane_e lane;
        logic  compact;
    } unpack_t;

    unpack_t u_q, u_d;
    logic    taken;

    always_comb begin
        u_d         = u_q;
        u_d.compact = compact_i;
        taken       = take_i && !empty_i;
        pop_o       = 1'b0;

        if (!compact_i) begin
            pop_o    = taken;
            sample_o = word_i[SAMPLE_W-1:0];
        end else begin
            pop_o    = taken && (u_q.lane == LANE_HI);
            sample_o = (u_q.lane == LANE_HI)
                     ? {word_i[WORD_W-1:HALF_W], {PAD_W{1'b0}}}
                     : {word_i[HALF_W-1:0], {PAD_W{1'b0}}};
        end

        if (compact_i != u_q.compact) begin
            u_d.lane = LANE_LO;
        end else if (compact_i && taken) begin
            u_d.lane = (u_q.lane == LANE_LO) ? LANE_HI : LANE_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
        end else begin
            u_q <= u_d;
        end
    end
endmodule

// File: rtl/achan_fifo_top.sv
module achan_fifo_top
    import achan_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_fifo_off,
    input  logic                 cfg_compact,
    input  logic [SLOT_CNT:0]    rx_ctrl,
    input  logic                 host_wr,
    input  logic [WORD_W-1:0]    host_wdata,
    input  logic                 host_rd,
    output logic [WORD_W-1:0]    host_rdata,
    output logic                 rx_overrun,
    input  logic                 rx_valid,
    input  logic [3:0]           rx_slot,
    input  logic [SAMPLE_W-1:0]  rx_sample,
    input  logic                 tx_take,
    output logic [SAMPLE_W-1:0]  tx_sample,
    output logic                 tx_full,
    output logic                 tx_empty,
    output logic                 rx_full,
    output logic                 rx_empty
);
    localparam int RXW = WORD_W + 1;

    logic [WORD_W-1:0] tx_push_word, tx_head;
    logic              tx_pop;
    logic              pk_push;
    logic [WORD_W-1:0] pk_word;
    logic [RXW-1:0]    rx_head;

    typedef struct packed {
        logic [RXW-1:0] rd;
    } host_t;

    host_t h_q, h_d;

    always_comb begin
        tx_push_word = cfg_compact ? host_wdata
                     : {{(WORD_W - SAMPLE_W){1'b0}}, host_wdata[SAMPLE_W-1:0]};
    end

    achan_fifo #(.DW(WORD_W), .DEPTH(DEPTH), .TAG_EN(1'b0)) u_tx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass_i    (cfg_fifo_off),
        .push_i      (host_wr),
        .push_data_i (tx_push_word),
        .pop_i       (tx_pop),
        .head_o      (tx_head),
        .full_o      (tx_full),
        .empty_o     (tx_empty)
    );

    achan_tx_unpack u_tx_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .compact_i (cfg_compact),
        .word_i    (tx_head),
        .empty_i   (tx_empty),
        .take_i    (tx_take),
        .pop_o     (tx_pop),
        .sample_o  (tx_sample)
    );

    achan_rx_pack u_rx_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .compact_i (cfg_compact),
        .ctrl_i    (rx_ctrl),
        .valid_i   (rx_valid),
        .slot_i    (rx_slot),
        .sample_i  (rx_sample),
        .push_o    (pk_push),
        .word_o    (pk_word)
    );

    achan_fifo #(.DW(RXW), .DEPTH(DEPTH), .TAG_EN(1'b1)) u_rx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass_i    (cfg_fifo_off),
        .push_i      (pk_push),
        .push_data_i ({1'b0, pk_word}),
        .pop_i       (host_rd),
        .head_o      (rx_head),
        .full_o      (rx_full),
        .empty_o     (rx_empty)
    );

    always_comb begin
        h_d = h_q;
        if (host_rd && !rx_empty) begin
            h_d.rd = rx_head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign host_rdata = h_q.rd[WORD_W-1:0];
    assign rx_overrun = h_q.rd[WORD_W];

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_empty) |=> ($stable(host_rdata) && $stable(rx_overrun))); // R7
endmodule

// File: tb/tb_achan_fifo_top.sv
`timescale 1ns/1ps
module tb_achan_fifo_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_fifo_off, cfg_compact;
    logic [12:0] rx_ctrl;
    logic        host_wr, host_rd;
    logic [31:0] host_wdata, host_rdata;
    logic        rx_overrun, rx_valid;
    logic [3:0]  rx_slot;
    logic [19:0] rx_sample, tx_sample;
    logic        tx_take, tx_full, tx_empty, rx_full, rx_empty;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    achan_fifo_top #(.DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_off(cfg_fifo_off), .cfg_compact(cfg_compact),
        .rx_ctrl(rx_ctrl), .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .rx_overrun(rx_overrun), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .rx_sample(rx_sample), .tx_take(tx_take), .tx_sample(tx_sample),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
    );

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [31:0] d);
        host_wr = 1'b1; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] d, output logic ov);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        d  = host_rdata;
        ov = rx_overrun;
    endtask

    task automatic rx_send(input logic [3:0] slot, input logic [19:0] s);
        rx_valid = 1'b1; rx_slot = slot; rx_sample = s;
        tick();
        rx_valid = 1'b0;
        tick();
    endtask

    task automatic tx_take_one(output logic [19:0] s);
        s = tx_sample;
        tx_take = 1'b1;
        tick();
        tx_take = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", {1'b0, host_rdata}, 33'h0);
        check("R1 overrun", {32'h0, rx_overrun}, 33'h0);
        check("R1 tx_sample", {13'h0, tx_sample}, 33'h0);
        check("R1 flags", {29'h0, tx_empty, rx_empty, tx_full, rx_full}, 33'b1100);
    endtask

    task automatic t_tx_normal();
        logic [19:0] s;
        host_write(32'hABC12345);
        host_write(32'h00000001);
        host_write(32'hFFFFFFFF);
        tx_take_one(s); check("R2 first", {13'h0, s}, 33'h12345);
        tx_take_one(s); check("R2 second", {13'h0, s}, 33'h00001);
        tx_take_one(s); check("R2 third", {13'h0, s}, 33'hFFFFF);
        check("R5 tx empty after drain", {32'h0, tx_empty}, 33'h1);
    endtask

    task automatic t_tx_full();
        logic [19:0] s;
        for (int i = 0; i < 4; i++) host_write(32'h100 + i);
        check("R5 tx full at depth", {32'h0, tx_full}, 33'h1);
        host_write(32'h999);
        for (int i = 0; i < 4; i++) begin
            tx_take_one(s);
            check("R8 queued word kept", {13'h0, s}, 33'h100 + i);
        end
        check("R8 extra write dropped", {32'h0, tx_empty}, 33'h1);
    endtask

    task automatic t_rx_gate();
        logic [31:0] d; logic ov;
        rx_ctrl = 13'b0000000001001;
        rx_send(4'd5, 20'h11111);
        check("R3 disabled slot", {32'h0, rx_empty}, 33'h1);
        rx_ctrl = 13'b0000000001000;
        rx_send(4'd3, 20'h22222);
        check("R3 rx enable off", {32'h0, rx_empty}, 33'h1);
        rx_ctrl = 13'h1FFF;
        rx_send(4'd0, 20'h33333);
        rx_send(4'd13, 20'h44444);
        check("R3 slot out of range", {32'h0, rx_empty}, 33'h1);
        rx_ctrl = 13'b0000000001001;
        rx_send(4'd3, 20'h7A5C3);
        check("R4 accepted", {32'h0, rx_empty}, 33'h0);
        host_read(d, ov);
        check("R4 read data", {1'b0, d}, 33'h0007A5C3);
    endtask

    task automatic t_rx_overrun();
        logic [31:0] d; logic ov;
        rx_ctrl = 13'h1FFF;
        for (int i = 1; i <= 4; i++) rx_send(4'd1, 20'h11111 * i);
        check("R5 rx full at depth", {32'h0, rx_full}, 33'h1);
        rx_send(4'd2, 20'h55555);
        for (int i = 1; i <= 4; i++) begin
            host_read(d, ov);
            check("R6 data in order", {1'b0, d}, {1'b0, 32'h11111 * i});
            check("R6 tag on newest", {32'h0, ov}, (i == 4) ? 33'h1 : 33'h0);
        end
        host_read(d, ov);
        check("R7 empty read keeps data", {1'b0, d}, 33'h00044444);
        check("R7 empty read keeps tag", {32'h0, ov}, 33'h1);
        rx_send(4'd7, 20'h66666);
        host_read(d, ov);
        check("R4 read after wrap", {ov, d}, 33'h000066666);
    endtask

    task automatic t_bypass();
        logic [31:0] d; logic ov; logic [19:0] s;
        cfg_fifo_off = 1'b1; tick();
        host_write(32'h00011111);
        check("R9 hold full", {32'h0, tx_full}, 33'h1);
        host_write(32'hFFF22222);
        tx_take_one(s);
        check("R9 overwrite", {13'h0, s}, 33'h22222);
        check("R9 consumed", {31'h0, tx_empty, tx_full}, 33'b10);
        rx_send(4'd1, 20'hA0A0A);
        host_read(d, ov);
        check("R10 clean store", {ov, d}, 33'h0000A0A0A);
        rx_send(4'd1, 20'hB0B0B);
        rx_send(4'd1, 20'hC0C0C);
        host_read(d, ov);
        check("R10 overwrite tagged", {ov, d}, 33'h1000C0C0C);
        host_read(d, ov);
        check("R7 hold empty read", {ov, d}, 33'h1000C0C0C);
    endtask

    task automatic t_flush();
        cfg_fifo_off = 1'b0; tick();
        host_write(32'h5);
        host_write(32'h6);
        check("R13 loaded", {32'h0, tx_empty}, 33'h0);
        cfg_fifo_off = 1'b1; tick();
        check("R13 flushed", {32'h0, tx_empty}, 33'h1);
        cfg_fifo_off = 1'b0; tick();
    endtask

    task automatic t_compact();
        logic [31:0] d; logic ov; logic [19:0] s;
        cfg_compact = 1'b1; tick();
        rx_send(4'd3, 20'hABCD0);
        check("R11 half word not readable", {32'h0, rx_empty}, 33'h1);
        rx_send(4'd4, 20'h12345);
        host_read(d, ov);
        check("R11 packed word", {ov, d}, 33'h01234ABCD);
        host_write(32'hDEADBEEF);
        tx_take_one(s);
        check("R12 low half", {13'h0, s}, 33'hBEEF0);
        check("R12 word kept", {32'h0, tx_empty}, 33'h0);
        tx_take_one(s);
        check("R12 high half", {13'h0, s}, 33'hDEAD0);
        check("R12 word removed", {32'h0, tx_empty}, 33'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_fifo_off = 1'b0; cfg_compact = 1'b0; rx_ctrl = '0;
        host_wr = 1'b0; host_wdata = '0; host_rd = 1'b0;
        rx_valid = 1'b0; rx_slot = '0; rx_sample = '0; tx_take = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_tx_normal();
        t_tx_full();
        t_rx_gate();
        t_rx_overrun();
        t_bypass();
        t_flush();
        t_compact();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule